// File: doc/BRIEF.md
# Background Memory Scrubber Controller

The scrubber walks a memory array from the lowest to the highest word whenever a periodic timer tick finds it idle. It reads each word through the ECC checker that sits in the read path. It then sorts the result into one of three cases: clean, recoverable or unrecoverable. A clean word costs one read and nothing else.

For a recoverable word, the controller does three things. It asks the symbol-steering unit to switch the failing symbol onto the spare. It logs the event. It then writes the corrected data back to the same address, so that the store passes through the newly steered spare lanes. An unrecoverable word is logged and left alone, and the scan moves on. No mirroring mode is needed for any of this.

The memory port is shared with normal traffic. A single grant input decides when the scrubber may present a request. A presented request stays up until the memory accepts it.

Top module: `scrub_ctrl`

## Requirements
- R1: A `period_tick` seen while idle starts one pass. The pass reads every address from 0 to 2**ADDR_W-1 in ascending order, exactly once each, and then returns to idle.
- R2: A `period_tick` that arrives while a pass is running has no effect. While idle, no memory request is made.
- R3: `mem_req` is high only in cycles where `grant` is high. Once a request has been presented, it is presented again in every later cycle with `grant` high, with the same `mem_we`, `mem_addr` and `mem_wdata`. This continues until a cycle in which `mem_req` and `mem_ack` are both high.
- R4: A read response is taken in the cycle `mem_rvalid` is high. `ecc_ue`=1 classifies the word as unrecoverable whatever `ecc_ce` is. `ecc_ce`=1 with `ecc_ue`=0 classifies it as recoverable. Both low means clean, and a clean word produces no log entry.
- R5: Each recoverable or unrecoverable word produces exactly one log entry. The entry is a single-cycle `log_valid` pulse carrying the word's address on `log_addr`, the `ecc_sym` value from its read response on `log_sym`, and `log_ue`=1 for unrecoverable or 0 for recoverable.
- R6: A recoverable word raises `steer_req` for one cycle, in the same cycle as its log entry, with `steer_sym` equal to the failing symbol. It is then followed by a write (`mem_we`=1) to the same address carrying the `mem_rdata` of its read response. This write comes before the next address is read.
- R7: An unrecoverable word causes no steering request and no write, and the scan continues with the next address.
- R8: While reset is applied, `mem_req`, `log_valid` and `steer_req` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_tick | input | 1 | Scrub interval tick; starts a pass when idle |
| grant | input | 1 | Arbiter permission to use the memory port this cycle |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | DATA_W | Corrected data for a write-back |
| mem_ack | input | 1 | Memory accepts the request when high together with mem_req |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DATA_W | Read data after ECC correction |
| ecc_ce | input | 1 | Recoverable error flag for the response |
| ecc_ue | input | 1 | Unrecoverable error flag for the response |
| ecc_sym | input | SYM_W | Index of the failing symbol |
| steer_req | output | 1 | One-cycle request to engage the spare symbol |
| steer_sym | output | SYM_W | Symbol to steer onto the spare |
| log_valid | output | 1 | One-cycle error log strobe |
| log_addr | output | ADDR_W | Address of the failing word |
| log_ue | output | 1 | 1 = unrecoverable, 0 = recoverable |
| log_sym | output | SYM_W | Failing symbol index |

## Verification
The first pass has no errors and full grant and accept. It proves the address walk and its request count on their own, without any error-handling cycles mixed in. The next passes place recoverable, unrecoverable and both-flags-set words at the first address, the last address and interior addresses. Grant and accept are withheld at random and the read latency varies, which separates correct hold-until-accept and write-before-next-read ordering from designs that drop or reorder requests. Extra ticks during a pass and a long quiet stretch afterwards show whether a tick restarts a running pass or whether the controller issues requests while idle.

// File: rtl/scrub_pkg.sv
`timescale 1ns/1ps
package scrub_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_CHECK,
    ST_WB,
    ST_NEXT
  } scrub_state_e;

  typedef enum logic [1:0] {
    ERR_NONE,
    ERR_CE,
    ERR_UE
  } scrub_err_e;

endpackage

// File: rtl/scrub_addr_ctr.sv
`timescale 1ns/1ps
module scrub_addr_ctr #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_d  = addr_q;
    addr_en = clr | inc;
    if (clr)      addr_d = '0;
    else if (inc) addr_d = addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;
  assign last = (addr_q == LAST_ADDR);

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !last) |=> (addr == $past(addr) + ADDR_W'(1)));

endmodule

// File: rtl/scrub_capture.sv
`timescale 1ns/1ps
module scrub_capture
  import scrub_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SYM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] rdata,
  input  logic              ce,
  input  logic              ue,
  input  logic [SYM_W-1:0]  sym,
  output logic [DATA_W-1:0] cap_data,
  output scrub_err_e        cap_kind,
  output logic [SYM_W-1:0]  cap_sym
);
  logic [DATA_W-1:0] data_q;
  logic [SYM_W-1:0]  sym_q;
  scrub_err_e        kind_q, kind_d;

  always_comb begin
    if (ue)      kind_d = ERR_UE;
    else if (ce) kind_d = ERR_CE;
    else         kind_d = ERR_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      sym_q  <= '0;
      kind_q <= ERR_NONE;
    end else if (cap_en) begin
      data_q <= rdata;
      sym_q  <= sym;
      kind_q <= kind_d;
    end
  end

  assign cap_data = data_q;
  assign cap_kind = kind_q;
  assign cap_sym  = sym_q;

  // R4
  ue_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && ue) |=> (cap_kind == ERR_UE));

endmodule

// File: rtl/scrub_seq.sv
`timescale 1ns/1ps
module scrub_seq
  import scrub_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         grant,
  input  logic         mem_ack,
  input  logic         mem_rvalid,
  input  logic         last,
  input  scrub_err_e   kind,
  output scrub_state_e state,
  output logic         addr_clr,
  output logic         addr_inc,
  output logic         cap_en,
  output logic         req,
  output logic         we
);
  scrub_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    cap_en   = 1'b0;
    req      = 1'b0;
    we       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tick) begin
          addr_clr = 1'b1;
          state_d  = ST_RD_REQ;
        end
      end
      ST_RD_REQ: begin
        req = grant;
        if (grant && mem_ack) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (mem_rvalid) begin
          cap_en  = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        state_d = (kind == ERR_CE) ? ST_WB : ST_NEXT;
      end
      ST_WB: begin
        req = grant;
        we  = 1'b1;
        if (grant && mem_ack) state_d = ST_NEXT;
      end
      ST_NEXT: begin
        if (last) begin
          state_d = ST_IDLE;
        end else begin
          addr_inc = 1'b1;
          state_d  = ST_RD_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !mem_ack) |=> (!grant || req));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !tick) |=> (state_q == ST_IDLE));

  // R2
  busy_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && tick) |=> !addr_clr);

endmodule

// File: rtl/scrub_ctrl.sv
`timescale 1ns/1ps
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SYM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_tick,
  input  logic              grant,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              ecc_ce,
  input  logic              ecc_ue,
  input  logic [SYM_W-1:0]  ecc_sym,
  output logic              steer_req,
  output logic [SYM_W-1:0]  steer_sym,
  output logic              log_valid,
  output logic [ADDR_W-1:0] log_addr,
  output logic              log_ue,
  output logic [SYM_W-1:0]  log_sym
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[RST_STAGES-1];

  scrub_state_e      state;
  scrub_err_e        cap_kind;
  logic [DATA_W-1:0] cap_data;
  logic [SYM_W-1:0]  cap_sym;
  logic [ADDR_W-1:0] addr;
  logic              last, addr_clr, addr_inc, cap_en, seq_req, seq_we;
  logic              in_check;

  scrub_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .tick       (period_tick),
    .grant      (grant),
    .mem_ack    (mem_ack),
    .mem_rvalid (mem_rvalid),
    .last       (last),
    .kind       (cap_kind),
    .state      (state),
    .addr_clr   (addr_clr),
    .addr_inc   (addr_inc),
    .cap_en     (cap_en),
    .req        (seq_req),
    .we         (seq_we)
  );

  scrub_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (addr_clr),
    .inc   (addr_inc),
    .addr  (addr),
    .last  (last)
  );

  scrub_capture #(.DATA_W(DATA_W), .SYM_W(SYM_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cap_en   (cap_en),
    .rdata    (mem_rdata),
    .ce       (ecc_ce),
    .ue       (ecc_ue),
    .sym      (ecc_sym),
    .cap_data (cap_data),
    .cap_kind (cap_kind),
    .cap_sym  (cap_sym)
  );

  assign in_check  = (state == ST_CHECK);
  assign mem_req   = seq_req;
  assign mem_we    = seq_we;
  assign mem_addr  = addr;
  assign mem_wdata = cap_data;

  assign log_valid = in_check && (cap_kind != ERR_NONE);
  assign log_ue    = (cap_kind == ERR_UE);
  assign log_addr  = addr;
  assign log_sym   = cap_sym;
  assign steer_req = in_check && (cap_kind == ERR_CE);
  assign steer_sym = cap_sym;

  // R5
  log_pulse_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    log_valid |=> !log_valid);

  // R6
  steer_with_log_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    steer_req |-> (log_valid && !log_ue));

  // R7
  no_wb_ue_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (log_valid && log_ue) |=> !mem_we);

  // R3
  req_grant_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_req |-> grant);

  // R6
  wb_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mem_req && mem_we && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata)));

endmodule

// File: tb/scrub_ctrl_tb_top.sv
`timescale 1ns/1ps
module scrub_ctrl_tb_top;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SYM_W  = 4;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_tick = 1'b0, grant = 1'b0, mem_ack = 1'b0, mem_rvalid = 1'b0;
  logic ecc_ce = 1'b0, ecc_ue = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [SYM_W-1:0]  ecc_sym = '0;
  logic mem_req, mem_we, steer_req, log_valid, log_ue;
  logic [ADDR_W-1:0] mem_addr, log_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [SYM_W-1:0]  steer_sym, log_sym;

  always #10 clk = ~clk;

  scrub_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYM_W(SYM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .grant(grant),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ecc_ce(ecc_ce), .ecc_ue(ecc_ue), .ecc_sym(ecc_sym),
    .steer_req(steer_req), .steer_sym(steer_sym), .log_valid(log_valid),
    .log_addr(log_addr), .log_ue(log_ue), .log_sym(log_sym)
  );

  int n_checks = 0;
  int n_fail = 0;

  // error map: 0 clean, 1 ce, 2 ue, 3 both flags
  int err_map [DEPTH];
  logic [DATA_W-1:0] mem_img [DEPTH];

  logic              exp_we   [$];
  logic [ADDR_W-1:0] exp_addr [$];
  logic [DATA_W-1:0] exp_data [$];
  logic [ADDR_W-1:0] exp_laddr [$];
  logic              exp_lue   [$];
  logic [SYM_W-1:0]  exp_lsym  [$];

  int grant_pct = 100;
  int ack_pct = 100;
  bit tick_next = 1'b0;
  int rd_cnt = 0;
  int rd_addr = 0;
  bit pend_v = 1'b0;
  logic pend_we;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [SYM_W-1:0] sym_of(input int a);
    return SYM_W'((a * 7 + 3) % (1 << SYM_W));
  endfunction

  function automatic void build_pass();
    for (int a = 0; a < DEPTH; a++) begin
      exp_we.push_back(1'b0); exp_addr.push_back(ADDR_W'(a)); exp_data.push_back('0);
      if (err_map[a] >= 2) begin
        exp_laddr.push_back(ADDR_W'(a)); exp_lue.push_back(1'b1); exp_lsym.push_back(sym_of(a));
      end else if (err_map[a] == 1) begin
        exp_laddr.push_back(ADDR_W'(a)); exp_lue.push_back(1'b0); exp_lsym.push_back(sym_of(a));
        exp_we.push_back(1'b1); exp_addr.push_back(ADDR_W'(a)); exp_data.push_back(mem_img[a]);
      end
    end
  endfunction

  task automatic monitor();
    if (mem_req) chk(grant == 1'b1, "R3", "req without grant", 0, 1);
    if (pend_v && grant) begin
      chk(mem_req && mem_we == pend_we && mem_addr == pend_addr &&
          (!pend_we || mem_wdata == pend_data), "R3", "request not held",
          longint'(mem_addr), longint'(pend_addr));
    end
    if (mem_req && mem_ack) begin
      pend_v = 1'b0;
      if (exp_we.size() == 0) begin
        chk(1'b0, "R2", "unexpected request addr", longint'(mem_addr), -1);
      end else begin
        logic w; logic [ADDR_W-1:0] a; logic [DATA_W-1:0] d;
        w = exp_we.pop_front(); a = exp_addr.pop_front(); d = exp_data.pop_front();
        chk(mem_we == w, w ? "R6" : "R7", "request kind", longint'(mem_we), longint'(w));
        chk(mem_addr == a, "R1", "request address", longint'(mem_addr), longint'(a));
        if (w) chk(mem_wdata == d, "R6", "write-back data", longint'(mem_wdata), longint'(d));
        if (!mem_we) begin
          rd_cnt = 1 + int'($urandom % 3);
          rd_addr = int'(mem_addr);
        end
      end
    end else if (mem_req) begin
      pend_v = 1'b1; pend_we = mem_we; pend_addr = mem_addr; pend_data = mem_wdata;
    end
    if (log_valid) begin
      if (exp_laddr.size() == 0) begin
        chk(1'b0, "R4", "unexpected log addr", longint'(log_addr), -1);
      end else begin
        logic [ADDR_W-1:0] la; logic lu; logic [SYM_W-1:0] ls;
        la = exp_laddr.pop_front(); lu = exp_lue.pop_front(); ls = exp_lsym.pop_front();
        chk(log_addr == la, "R5", "log address", longint'(log_addr), longint'(la));
        chk(log_ue == lu, "R4", "log class", longint'(log_ue), longint'(lu));
        chk(log_sym == ls, "R5", "log symbol", longint'(log_sym), longint'(ls));
        chk(steer_req == !lu, lu ? "R7" : "R6", "steer request", longint'(steer_req), longint'(!lu));
        if (!lu) chk(steer_sym == ls, "R6", "steer symbol", longint'(steer_sym), longint'(ls));
      end
    end else if (steer_req) begin
      chk(1'b0, "R6", "steer without log", 1, 0);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #2;
    grant = (int'($urandom % 100) < grant_pct);
    mem_ack = (int'($urandom % 100) < ack_pct);
    period_tick = tick_next;
    tick_next = 1'b0;
    mem_rvalid = 1'b0; ecc_ce = 1'b0; ecc_ue = 1'b0;
    mem_rdata = DATA_W'($urandom); ecc_sym = SYM_W'($urandom);
    if (rd_cnt > 0) begin
      rd_cnt--;
      if (rd_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = mem_img[rd_addr];
        ecc_ce = (err_map[rd_addr] & 1) != 0;
        ecc_ue = (err_map[rd_addr] & 2) != 0;
        ecc_sym = sym_of(rd_addr);
      end
    end
    #1;
    monitor();
  endtask

  task automatic run_pass(input string rq);
    int guard;
    build_pass();
    tick_next = 1'b1;
    guard = 0;
    while ((exp_we.size() != 0 || exp_laddr.size() != 0) && guard < 20000) begin
      cycle();
      guard++;
    end
    repeat (12) cycle();
    chk(exp_we.size() == 0, rq, "requests left", longint'(exp_we.size()), 0);
    chk(exp_laddr.size() == 0, rq, "log entries left", longint'(exp_laddr.size()), 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      err_map[a] = 0;
      mem_img[a] = DATA_W'(32'h5A00_0000 ^ (a * 32'h0101_0103));
    end
    // R8: outputs quiet under reset
    repeat (4) begin
      @(posedge clk); #3;
      chk(!mem_req && !log_valid && !steer_req, "R8", "outputs in reset",
          longint'({mem_req, log_valid, steer_req}), 0);
    end
    rst_n = 1'b1;
    repeat (5) cycle();
    chk(!mem_req, "R2", "idle after reset", longint'(mem_req), 0);

    // R1: clean pass, free port
    grant_pct = 100; ack_pct = 100;
    run_pass("R1");

    // R4 R6 R7: errors at edges and inside, contended port
    err_map[0] = 1; err_map[1] = 2; err_map[2] = 3; err_map[5] = 1;
    err_map[40] = 2; err_map[DEPTH-1] = 1;
    grant_pct = 60; ack_pct = 55;
    build_pass();
    tick_next = 1'b1;
    for (int i = 0; i < 20000 && (exp_we.size() != 0 || exp_laddr.size() != 0); i++) begin
      cycle();
      if (i == 30 || i == 200) tick_next = 1'b1; // R2: ticks mid-pass ignored
    end
    repeat (12) cycle();
    chk(exp_we.size() == 0, "R6", "requests left", longint'(exp_we.size()), 0);
    chk(exp_laddr.size() == 0, "R5", "log entries left", longint'(exp_laddr.size()), 0);

    // R2: long idle stretch, any request pops an empty queue
    for (int i = 0; i < 60; i++) begin
      cycle();
      if (mem_req) chk(1'b0, "R2", "request while idle", 1, 0);
    end
    chk(1'b1, "R2", "idle stretch", 0, 0);

    // R3 R6 R7: new error pattern, sparse grant
    for (int a = 0; a < DEPTH; a++) err_map[a] = 0;
    err_map[3] = 3; err_map[4] = 1; err_map[10] = 1; err_map[DEPTH-1] = 2;
    for (int a = 0; a < DEPTH; a++) mem_img[a] = DATA_W'($urandom);
    grant_pct = 35; ack_pct = 70;
    run_pass("R6");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule